// File: doc/BRIEF.md
# Boolean-Group Fetch and Execute Sequencer

This block is the control sequencer of a small 36-bit, word-addressed processor subset. It holds the program counter, the instruction fields, an effective-address register and an operand register, and it drives one shared 32-word memory through a single address selector. The low memory words also act as the accumulators. Each instruction is fetched in one cycle. Its effective address is then resolved by a loop that stays in one state, applying indexing before indirection until both are cleared. After that the instruction runs as a member of the boolean group.

In a boolean-group opcode, four bits hold a truth table. Two more bits pick the operand source and where the result goes: the accumulator, memory, or both. Any other opcode stops the sequencer. It raises a halt flag that stays set until reset. A side port lets the surrounding environment preload memory words and observe them.

Top module: `boolx_core`

## Requirements
- R1: While reset is high the halt output is 0. After reset is released, the sequencer fetches from address 0.
- R2: Fetch takes one cycle. It reads the word at the program counter. Word bits [35:27] become the opcode, [26:23] the accumulator number, [22] the indirect flag, [21:18] the index number and [17:0] the effective address. The program counter then advances by one.
- R3: When the index number is nonzero, one cycle adds bits [17:0] of the word at that index location to the effective address, modulo 2^18, and clears the index number. Indexing takes priority over indirection.
- R4: When the index number is zero and the indirect flag is set, one cycle reloads the indirect flag, index number and effective address from bits [22], [21:18] and [17:0] of the word at the effective address. Resolution repeats until both the flag and the index number are clear.
- R5: An opcode whose bits [8:6] are not 100 sets the halt output one cycle after resolution ends. Halt then stays 1 and no memory word changes until reset.
- R6: The mode field is opcode bits [1:0]. Mode 01 takes the zero-extended 18-bit effective address as the operand. Every other mode takes the memory word at the effective address.
- R7: The function field is opcode bits [5:2], treated as fn[3:0]. Each result bit is fn[{~operand_bit, ~accumulator_bit}], so 0001 is AND, 0110 is XOR, 0111 is OR and 1000 is NOR.
- R8: Mode 10 writes the result only to the effective address. Mode 11 writes it to the accumulator and then to the effective address. Modes 00 and 01 write it only to the accumulator.
- R9: A boolean instruction takes 3 + (index and indirect steps) + (2 for mode 11, else 1) cycles. The next fetch follows at once.
- R10: Memory is addressed by the low 5 bits of whichever source the selector picks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| halt | output | 1 | Sticky flag for an unimplemented opcode |
| mon_we | input | 1 | Side-port write enable; takes priority over the sequencer |
| mon_addr | input | 5 | Side-port word address |
| mon_wdata | input | 36 | Side-port write data |
| mon_rdata | output | 36 | Combinational read of the word at mon_addr |

## Verification
Every result lands on the clock edge that ends its write state. Counted from the previous instruction's completion, that is 3 + steps + 1 edges, or + 2 edges in mode 11. The bench's instruction-level model returns that count for each instruction. The bench waits exactly that many edges, checking halt 1 ns after every edge, and then compares all 32 memory words. For an illegal opcode the halt flag is due on the edge after the last resolution step, and it is checked there and on every edge after it.

// File: rtl/boolx_pkg.sv
package boolx_pkg;
    parameter int WORD_W = 36;
    parameter int HALF_W = WORD_W / 2;
    parameter int OP_W   = 9;
    parameter int ACC_W  = 4;
    parameter int IDX_W  = 4;
    parameter int FN_W   = 4;
    parameter int MODE_W = 2;

    localparam int IDX_LO = HALF_W;
    localparam int IND_B  = HALF_W + IDX_W;
    localparam int ACC_LO = IND_B + 1;
    localparam int OP_LO  = WORD_W - OP_W;

    localparam logic [2:0]        GROUP_BOOL = 3'b100;
    localparam logic [MODE_W-1:0] MODE_IMM   = 2'b01;
    localparam logic [MODE_W-1:0] MODE_MEM   = 2'b10;
    localparam logic [MODE_W-1:0] MODE_BOTH  = 2'b11;

    typedef enum logic [2:0] {
        ST_FETCH   = 3'd0,
        ST_RESOLVE = 3'd1,
        ST_COMBINE = 3'd2,
        ST_WR_ACC  = 3'd3,
        ST_WR_EA   = 3'd4,
        ST_HALT    = 3'd5
    } seq_state_e;

    typedef enum logic [1:0] {
        SEL_PC  = 2'd0,
        SEL_IDX = 2'd1,
        SEL_EA  = 2'd2,
        SEL_ACC = 2'd3
    } addr_sel_e;

    typedef struct packed {
        seq_state_e        state;
        logic [HALF_W-1:0] pc;
        logic [OP_W-1:0]   op;
        logic [ACC_W-1:0]  acc;
        logic              ind;
        logic [IDX_W-1:0]  idx;
        logic [HALF_W-1:0] ea;
        logic [WORD_W-1:0] opr;
        logic              halt;
    } seq_regs_t;
endpackage

// File: rtl/boolx_mem.sv
module boolx_mem #(
    parameter int DEPTH = 32,
    parameter int W     = 36,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          core_we,
    input  logic [AW-1:0] core_addr,
    input  logic [W-1:0]  core_wdata,
    output logic [W-1:0]  core_rdata,
    input  logic          ext_we,
    input  logic [AW-1:0] ext_addr,
    input  logic [W-1:0]  ext_wdata,
    output logic [W-1:0]  ext_rdata
);
    logic [W-1:0] words_q [DEPTH];

    always_ff @(posedge clk) begin
        if (ext_we) begin
            words_q[ext_addr] <= ext_wdata;
        end else if (core_we) begin
            words_q[core_addr] <= core_wdata;
        end
    end

    assign core_rdata = words_q[core_addr];
    assign ext_rdata  = words_q[ext_addr];
endmodule

// File: rtl/boolx_addr_mux.sv
module boolx_addr_mux
    import boolx_pkg::*;
#(
    parameter int AW = 5
) (
    input  addr_sel_e         sel,
    input  logic [HALF_W-1:0] pc,
    input  logic [IDX_W-1:0]  idx,
    input  logic [HALF_W-1:0] ea,
    input  logic [ACC_W-1:0]  acc,
    output logic [AW-1:0]     addr
);
    logic [HALF_W-1:0] wide;

    always_comb begin
        unique case (sel)
            SEL_PC:  wide = pc;
            SEL_IDX: wide = HALF_W'(idx);
            SEL_EA:  wide = ea;
            default: wide = HALF_W'(acc);
        endcase
        addr = wide[AW-1:0];
    end
endmodule

// File: rtl/boolx_fn.sv
module boolx_fn #(
    parameter int W    = 36,
    parameter int FN_N = 4
) (
    input  logic [FN_N-1:0] fn,
    input  logic [W-1:0]    opd,
    input  logic [W-1:0]    accw,
    output logic [W-1:0]    res
);
    for (genvar b = 0; b < W; b++) begin : g_bit
        assign res[b] = fn[{~opd[b], ~accw[b]}];
    end
endmodule

// File: rtl/boolx_core.sv
module boolx_core
    import boolx_pkg::*;
#(
    parameter int DEPTH = 32,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    output logic              halt,
    input  logic              mon_we,
    input  logic [AW-1:0]     mon_addr,
    input  logic [WORD_W-1:0] mon_wdata,
    output logic [WORD_W-1:0] mon_rdata
);
    seq_regs_t         r_q, r_d;
    addr_sel_e         sel_d;
    logic              mem_we_d;
    logic [AW-1:0]     mem_addr;
    logic [WORD_W-1:0] mem_rd;
    logic [WORD_W-1:0] fn_res;
    logic [MODE_W-1:0] mode;
    logic [FN_W-1:0]   fn;

    assign mode = r_q.op[MODE_W-1:0];
    assign fn   = r_q.op[MODE_W +: FN_W];
    assign halt = r_q.halt;

    boolx_addr_mux #(.AW(AW)) u_mux (
        .sel(sel_d), .pc(r_q.pc), .idx(r_q.idx), .ea(r_q.ea),
        .acc(r_q.acc), .addr(mem_addr)
    );

    boolx_mem #(.DEPTH(DEPTH), .W(WORD_W)) u_mem (
        .clk(clk), .core_we(mem_we_d), .core_addr(mem_addr),
        .core_wdata(r_q.opr), .core_rdata(mem_rd),
        .ext_we(mon_we), .ext_addr(mon_addr), .ext_wdata(mon_wdata),
        .ext_rdata(mon_rdata)
    );

    boolx_fn #(.W(WORD_W), .FN_N(FN_W)) u_fn (
        .fn(fn), .opd(r_q.opr), .accw(mem_rd), .res(fn_res)
    );

    always_comb begin
        r_d      = r_q;
        sel_d    = SEL_PC;
        mem_we_d = 1'b0;
        unique case (r_q.state)
            ST_FETCH: begin
                sel_d      = SEL_PC;
                r_d.op     = mem_rd[OP_LO +: OP_W];
                r_d.acc    = mem_rd[ACC_LO +: ACC_W];
                r_d.ind    = mem_rd[IND_B];
                r_d.idx    = mem_rd[IDX_LO +: IDX_W];
                r_d.ea     = mem_rd[HALF_W-1:0];
                r_d.pc     = r_q.pc + 1'b1;
                r_d.state  = ST_RESOLVE;
            end
            ST_RESOLVE: begin
                if (r_q.idx != '0) begin
                    sel_d   = SEL_IDX;
                    r_d.ea  = r_q.ea + mem_rd[HALF_W-1:0];
                    r_d.idx = '0;
                end else if (r_q.ind) begin
                    sel_d   = SEL_EA;
                    r_d.ind = mem_rd[IND_B];
                    r_d.idx = mem_rd[IDX_LO +: IDX_W];
                    r_d.ea  = mem_rd[HALF_W-1:0];
                end else if (r_q.op[OP_W-1 -: 3] == GROUP_BOOL) begin
                    sel_d     = SEL_EA;
                    r_d.opr   = (mode == MODE_IMM) ? {{(WORD_W-HALF_W){1'b0}}, r_q.ea} : mem_rd;
                    r_d.state = ST_COMBINE;
                end else begin
                    r_d.halt  = 1'b1;
                    r_d.state = ST_HALT;
                end
            end
            ST_COMBINE: begin
                sel_d     = SEL_ACC;
                r_d.opr   = fn_res;
                r_d.state = (mode == MODE_MEM) ? ST_WR_EA : ST_WR_ACC;
            end
            ST_WR_ACC: begin
                sel_d     = SEL_ACC;
                mem_we_d  = 1'b1;
                r_d.state = (mode == MODE_BOTH) ? ST_WR_EA : ST_FETCH;
            end
            ST_WR_EA: begin
                sel_d     = SEL_EA;
                mem_we_d  = 1'b1;
                r_d.state = ST_FETCH;
            end
            default: begin
                r_d = r_q;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    // R5: once raised, halt holds until reset
    p_halt_sticky_r5: assert property (@(posedge clk) disable iff (rst)
        r_q.halt |=> r_q.halt);

    // R5: a halted sequencer never writes memory
    p_no_write_halted_r5: assert property (@(posedge clk) disable iff (rst)
        r_q.halt |-> !mem_we_d);

    // R2: every fetch advances the program counter by one
    p_fetch_pc_r2: assert property (@(posedge clk) disable iff (rst)
        (r_q.state == ST_FETCH) |=> (r_q.pc == $past(r_q.pc) + 1'b1));

    // R3: an indexing step leaves the index number cleared
    p_idx_clear_r3: assert property (@(posedge clk) disable iff (rst)
        (r_q.state == ST_RESOLVE && r_q.idx != '0) |=> (r_q.idx == '0));

    // R8: the accumulator write goes to the accumulator address
    p_acc_write_r8: assert property (@(posedge clk) disable iff (rst)
        (r_q.state == ST_WR_ACC) |-> (mem_we_d && mem_addr == AW'(r_q.acc)));

    // R8: the memory-only mode never passes through the accumulator write
    p_mem_mode_r8: assert property (@(posedge clk) disable iff (rst)
        (r_q.state == ST_COMBINE && mode == MODE_MEM) |=> (r_q.state == ST_WR_EA));
endmodule

// File: tb/sim_boolx_core.sv
module sim_boolx_core;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        halt;
    logic        mon_we = 1'b0;
    logic [4:0]  mon_addr = '0;
    logic [35:0] mon_wdata = '0;
    logic [35:0] mon_rdata;

    int checks = 0;
    int fails  = 0;
    bit wd_hit = 1'b0;

    logic [35:0] m [32];
    int pc_m;

    always #5ns clk = ~clk;

    boolx_core u0 (
        .clk(clk), .rst(rst), .halt(halt), .mon_we(mon_we),
        .mon_addr(mon_addr), .mon_wdata(mon_wdata), .mon_rdata(mon_rdata)
    );

    function automatic logic [35:0] ins(logic [3:0] f, logic [1:0] mm, logic [3:0] ac,
                                        logic i, logic [3:0] x, logic [17:0] e);
        return {3'b100, f, mm, ac, i, x, e};
    endfunction

    task automatic check(string tag, logic [35:0] act, logic [35:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic poke(int a, logic [35:0] v);
        m[a] = v;
        @(negedge clk);
        mon_we = 1'b1; mon_addr = 5'(a); mon_wdata = v;
        @(negedge clk);
        mon_we = 1'b0;
    endtask

    task automatic compare_mem(string tag);
        for (int a = 0; a < 32; a++) begin
            mon_addr = 5'(a);
            #0.1ns;
            check(tag, mon_rdata, m[a]);
        end
    endtask

    // instruction-level model: updates m, returns edge count and illegal flag
    task automatic model_step(output int cyc, output bit ill, output string tag);
        logic [35:0] w, opd, acw, res;
        logic [8:0]  op;
        logic [3:0]  ac, x, f;
        logic        i;
        logic [17:0] ea;
        logic [1:0]  mm;
        w = m[pc_m]; pc_m++;
        op = w[35:27]; ac = w[26:23]; i = w[22]; x = w[21:18]; ea = w[17:0];
        cyc = 1; ill = 1'b0; tag = "R2 R6 R7 R8 R9";
        forever begin
            if (x != 0) begin
                ea = ea + m[x][17:0]; x = 0; cyc++; tag = "R3 R10";
            end else if (i) begin
                w = m[ea[4:0]]; i = w[22]; x = w[21:18]; ea = w[17:0]; cyc++; tag = "R4";
            end else break;
        end
        cyc++;
        if (op[8:6] != 3'b100) begin ill = 1'b1; return; end
        mm = op[1:0]; f = op[5:2];
        opd = (mm == 2'b01) ? {18'b0, ea} : m[ea[4:0]];
        acw = m[ac];
        for (int b = 0; b < 36; b++) res[b] = f[{~opd[b], ~acw[b]}];
        cyc++;
        if (mm == 2'b10) begin m[ea[4:0]] = res; cyc++; end
        else if (mm == 2'b11) begin m[ac] = res; m[ea[4:0]] = res; cyc += 2; end
        else begin m[ac] = res; cyc++; end
    endtask

    task automatic run_all();
        int cyc;
        bit ill;
        string tag;
        for (int a = 0; a < 32; a++) m[a] = '0;
        @(negedge clk);
        check("R1 halt in reset", {35'b0, halt}, 36'd0);
        for (int a = 0; a < 32; a++) poke(a, 36'd0);
        poke(0, ins(4'b0001, 2'b00, 4'd13, 1'b0, 4'd0, 18'd20));   // AND to acc
        poke(1, ins(4'b0111, 2'b01, 4'd14, 1'b0, 4'd0, 18'h155));  // OR immediate
        poke(2, ins(4'b0110, 2'b10, 4'd15, 1'b0, 4'd0, 18'd21));   // XOR to memory
        poke(3, ins(4'b1000, 2'b11, 4'd9, 1'b1, 4'd10, 18'd2));    // NOR both, index-indirect-index
        poke(4, ins(4'b0110, 2'b00, 4'd13, 1'b1, 4'd0, 18'd23));   // XOR, double indirect
        poke(5, ins(4'b0111, 2'b10, 4'd13, 1'b0, 4'd12, 18'd28));  // OR, wrapping index
        poke(9,  36'h0FF00FF00);
        poke(10, 36'h500000014);
        poke(11, 36'h000000015);
        poke(12, 36'h00003FFFF);
        poke(13, 36'hF0F0F0F0F);
        poke(14, 36'h123456789);
        poke(15, 36'hAAAAAAAAA);
        poke(20, 36'hFFFF00FFF);
        poke(21, 36'h333333333);
        poke(22, {9'd0, 4'd0, 1'b0, 4'd11, 18'd3});
        poke(23, {9'd0, 4'd0, 1'b1, 4'd0, 18'd25});
        poke(24, 36'h0F0F0F0F0);
        poke(25, {9'd0, 4'd0, 1'b0, 4'd0, 18'd26});
        poke(26, 36'h987654321);
        poke(27, 36'h00000FFFF);
        @(negedge clk);
        rst = 1'b0;
        pc_m = 0;
        for (int n = 0; n < 7; n++) begin
            model_step(cyc, ill, tag);
            for (int c = 1; c <= cyc; c++) begin
                @(posedge clk); #1ns;
                // R5 R9: halt due only on the edge that ends resolution of an illegal opcode
                check("R5 R9 halt timing", {35'b0, halt}, {35'b0, ill && c == cyc});
            end
            compare_mem(tag);
            if (ill) break;
        end
        for (int c = 0; c < 20; c++) begin
            @(posedge clk); #1ns;
            check("R5 halt sticky", {35'b0, halt}, 36'd1);
        end
        compare_mem("R5 no writes while halted");
        rst = 1'b1;
        @(posedge clk); #1ns;
        check("R1 reset clears halt", {35'b0, halt}, 36'd0);
    endtask

    initial begin
        fork
            run_all();
            begin #1ms; wd_hit = 1'b1; end
        join_any
        if (wd_hit) begin
            checks++; fails++;
            $display("FAIL watchdog actual=running expected=done");
        end
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule